// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps one atomic reservation for each hardware thread context and decides whether each store-conditional succeeds. A load-linked opens a reservation on a 64-byte line. When the local cache does not already hold that line exclusively, the block asks the fabric for the line with intent to modify and waits for the fill. A fill that comes back without ownership does not raise an error. The load-linked still completes, the reservation is silently marked failed, and the failure shows up only when the store-conditional runs.

Coherence snoops are settled by priority. When a snoop hits a live reservation, the holder keeps the line if its context priority is at least the snooper's priority, and the snoop is refused. Otherwise the line is yielded and every reservation on it is dropped. For each context the block also drives a mode flag that tells the memory-ordering logic to run sequentially consistent from the load-linked until its store-conditional.

Core requests enter on a valid/ready channel and completions leave on a valid/ready channel. Once a request is accepted, no further request is taken until its completion has been handed over, so only one request is in flight at a time. A completion is held, unchanged, until `done_ready` is high. The fetch channel is also valid/ready: the fetch address stays fixed until `fetch_ready`. Fills and snoops cannot be back-pressured. A fill is taken in the cycle it is presented, and every snoop gets a response exactly one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked with `req_line_excl`=0 drives `fetch_valid` in the cycle after acceptance. `fetch_addr` is the request line with its low 6 bits cleared, and it is held until `fetch_ready`. No completion appears before `fill_valid`.
- R2: A load-linked with `req_line_excl`=1 makes no fetch. It completes in the cycle after acceptance with `done_is_sc`=0 and opens a live reservation.
- R3: A fill with `fill_excl`=0 still completes the load-linked (`done_is_sc`=0, `done_sc_ok`=0) and leaves the reservation failed. A later store-conditional to that line returns `done_sc_ok`=0.
- R4: A store-conditional completes one cycle after acceptance with `done_is_sc`=1. `done_sc_ok`=1 only if its context holds a live reservation whose line (address bits above bit 5) equals the store's line; otherwise it fails.
- R5: Every store-conditional clears its context's reservation, whether it succeeds or fails, so a second store-conditional fails.
- R6: A new load-linked replaces the earlier reservation of the same context.
- R7: Each cycle with `snoop_valid` is followed by exactly one cycle of `snoop_rsp_valid`. `snoop_rsp_refuse`=1 only when some live reservation on the snooped line has priority >= `snoop_prio`; a tie goes to the holder. The reservation is kept. Context c's priority is `ctx_prio[c*3 +: 3]`, and a larger value means a higher priority.
- R8: If the snoop is not refused, every live reservation on the snooped line is cleared. A store-conditional accepted in the same cycle as such a snoop already sees the cleared reservation.
- R9: `sc_mode[c]` is 1 from the cycle after a load-linked of context c is accepted until its store-conditional is accepted, and 0 in the cycle after that.
- R10: `req_ready` is 0 while a fetch or fill is outstanding or a completion has not been taken. A completion with `done_valid`=1 keeps its fields until `done_ready`.
- R11: After reset, `req_ready`=1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted when both are high |
| req_is_sc | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_ctx | input | 2 | Thread context of the request |
| req_addr | input | 32 | Byte address of the access |
| req_line_excl | input | 1 | Line already held exclusively by the local cache |
| done_valid | output | 1 | Completion valid |
| done_ready | input | 1 | Completion taken when both are high |
| done_ctx | output | 2 | Context of the completion |
| done_is_sc | output | 1 | Completion is a store-conditional |
| done_sc_ok | output | 1 | Store-conditional succeeded |
| fetch_valid | output | 1 | Fetch-with-intent-to-modify request |
| fetch_ready | input | 1 | Fabric accepts the fetch |
| fetch_addr | output | 32 | Line-aligned fetch address |
| fill_valid | input | 1 | Fill for the outstanding fetch |
| fill_excl | input | 1 | Fill granted exclusive ownership |
| snoop_valid | input | 1 | Incoming coherence snoop |
| snoop_addr | input | 32 | Snooped address |
| snoop_prio | input | 3 | Snooper's priority |
| snoop_rsp_valid | output | 1 | Snoop response, one cycle after the snoop |
| snoop_rsp_refuse | output | 1 | 1 = holder keeps the line, 0 = line yielded |
| ctx_prio | input | 12 | Priority of each context, 3 bits per context |
| sc_mode | output | 4 | Per-context request for sequentially consistent ordering |

## Verification
The hardest state to reach is a store-conditional accepted in the same cycle as a snoop that hits its own line, together with snoops whose priority exactly equals the holder's. The bench reaches both by placing the request and the snoop at the same falling edge, with hand-set priorities. A long random phase then uses only three lines and random low address bits, so that snoops, replacements and refusals collide often. A cycle-accurate reference model is compared against every output on every clock.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } ctrl_st_e;
endpackage

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_set,
  input  logic              ll_live,
  input  logic [LINE_W-1:0] ll_line,
  input  logic              fill_upd,
  input  logic              fill_excl,
  input  logic              sc_clr,
  input  logic              snp_kill,
  output logic              open_o,
  output logic              live_o,
  output logic [LINE_W-1:0] line_o
);
  // A request or fill in this cycle overrides a kill: the snoop judged the old state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      live_o <= 1'b0;
      line_o <= '0;
    end else if (sc_clr) begin
      open_o <= 1'b0;
      live_o <= 1'b0;
    end else if (ll_set) begin
      open_o <= 1'b1;
      live_o <= ll_live;
      line_o <= ll_line;
    end else if (fill_upd) begin
      live_o <= fill_excl;
    end else if (snp_kill) begin
      live_o <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_snoop_judge.sv
module llsc_snoop_judge #(
  parameter int NUM_CTX = 4,
  parameter int LINE_W  = 26,
  parameter int PRIO_W  = 3
) (
  input  logic                      snp_valid,
  input  logic [LINE_W-1:0]         snp_line,
  input  logic [PRIO_W-1:0]         snp_prio,
  input  logic [NUM_CTX-1:0]        live_i,
  input  logic [NUM_CTX*LINE_W-1:0] lines_i,
  input  logic [NUM_CTX*PRIO_W-1:0] prios_i,
  output logic [NUM_CTX-1:0]        kill_o,
  output logic                      refuse_o
);
  logic [NUM_CTX-1:0] hit;
  logic [NUM_CTX-1:0] holder_wins;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    assign hit[g] = snp_valid && live_i[g] &&
                    (lines_i[g*LINE_W +: LINE_W] == snp_line);
    // ties resolve in favour of the holder
    assign holder_wins[g] = hit[g] && (prios_i[g*PRIO_W +: PRIO_W] >= snp_prio);
  end

  assign refuse_o = |holder_wins;
  assign kill_o   = refuse_o ? '0 : hit;
endmodule

// File: rtl/llsc_req_ctrl.sv
module llsc_req_ctrl
  import llsc_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2,
  parameter int LINE_W  = 26
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_is_sc,
  input  logic [CTX_W-1:0]          req_ctx,
  input  logic [LINE_W-1:0]         req_line,
  input  logic                      req_line_excl,
  output logic                      fetch_valid,
  input  logic                      fetch_ready,
  output logic [LINE_W-1:0]         fetch_line,
  input  logic                      fill_valid,
  input  logic [NUM_CTX-1:0]        live_now,
  input  logic [NUM_CTX*LINE_W-1:0] lines_i,
  output logic [NUM_CTX-1:0]        ll_set,
  output logic                      ll_live,
  output logic [NUM_CTX-1:0]        fill_upd,
  output logic [NUM_CTX-1:0]        sc_clr,
  output logic                      done_valid,
  input  logic                      done_ready,
  output logic [CTX_W-1:0]          done_ctx,
  output logic                      done_is_sc,
  output logic                      done_sc_ok
);
  ctrl_st_e           st_q;
  logic [CTX_W-1:0]   cur_ctx_q;
  logic [LINE_W-1:0]  cur_line_q;
  logic               dv_q, dsc_q, dok_q;
  logic               req_fire, sc_hit;
  logic [NUM_CTX-1:0] req_one, cur_one;

  assign req_ready = (st_q == ST_IDLE) && !dv_q;
  assign req_fire  = req_valid && req_ready;
  assign req_one   = NUM_CTX'(1) << req_ctx;
  assign cur_one   = NUM_CTX'(1) << cur_ctx_q;
  // the live vector already reflects a snoop that yields in this cycle
  assign sc_hit    = live_now[req_ctx] &&
                     (lines_i[req_ctx*LINE_W +: LINE_W] == req_line);

  assign ll_set   = (req_fire && !req_is_sc) ? req_one : '0;
  assign ll_live  = req_line_excl;
  assign sc_clr   = (req_fire && req_is_sc) ? req_one : '0;
  assign fill_upd = (st_q == ST_WAIT && fill_valid) ? cur_one : '0;

  assign fetch_valid = (st_q == ST_FETCH);
  assign fetch_line  = cur_line_q;
  assign done_valid  = dv_q;
  assign done_ctx    = cur_ctx_q;
  assign done_is_sc  = dsc_q;
  assign done_sc_ok  = dok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cur_ctx_q  <= '0;
      cur_line_q <= '0;
      dv_q       <= 1'b0;
      dsc_q      <= 1'b0;
      dok_q      <= 1'b0;
    end else begin
      if (dv_q && done_ready) dv_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_fire) begin
          cur_ctx_q  <= req_ctx;
          cur_line_q <= req_line;
          if (req_is_sc) begin
            dv_q  <= 1'b1;
            dsc_q <= 1'b1;
            dok_q <= sc_hit;
          end else if (req_line_excl) begin
            dv_q  <= 1'b1;
            dsc_q <= 1'b0;
            dok_q <= 1'b0;
          end else begin
            st_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (fetch_ready) st_q <= ST_WAIT;
        ST_WAIT: if (fill_valid) begin
          dv_q  <= 1'b1;
          dsc_q <= 1'b0;
          dok_q <= 1'b0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NUM_CTX    = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int PRIO_W     = 3,
  localparam int CTX_W     = $clog2(NUM_CTX),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_is_sc,
  input  logic [CTX_W-1:0]          req_ctx,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_line_excl,
  output logic                      done_valid,
  input  logic                      done_ready,
  output logic [CTX_W-1:0]          done_ctx,
  output logic                      done_is_sc,
  output logic                      done_sc_ok,
  output logic                      fetch_valid,
  input  logic                      fetch_ready,
  output logic [ADDR_W-1:0]         fetch_addr,
  input  logic                      fill_valid,
  input  logic                      fill_excl,
  input  logic                      snoop_valid,
  input  logic [ADDR_W-1:0]         snoop_addr,
  input  logic [PRIO_W-1:0]         snoop_prio,
  output logic                      snoop_rsp_valid,
  output logic                      snoop_rsp_refuse,
  input  logic [NUM_CTX*PRIO_W-1:0] ctx_prio,
  output logic [NUM_CTX-1:0]        sc_mode
);
  logic [NUM_CTX-1:0]        open_v, live_v, kill_v, live_now;
  logic [NUM_CTX-1:0]        ll_set_v, fill_upd_v, sc_clr_v;
  logic [NUM_CTX*LINE_W-1:0] lines_v;
  logic                      ll_live, refuse;
  logic [LINE_W-1:0]         fetch_line;
  logic                      unused_offsets;

  assign unused_offsets = ^{req_addr[OFF_W-1:0], snoop_addr[OFF_W-1:0]};

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    llsc_rsv_slot #(.LINE_W(LINE_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ll_set    (ll_set_v[g]),
      .ll_live   (ll_live),
      .ll_line   (req_addr[ADDR_W-1:OFF_W]),
      .fill_upd  (fill_upd_v[g]),
      .fill_excl (fill_excl),
      .sc_clr    (sc_clr_v[g]),
      .snp_kill  (kill_v[g]),
      .open_o    (open_v[g]),
      .live_o    (live_v[g]),
      .line_o    (lines_v[g*LINE_W +: LINE_W])
    );
  end

  llsc_snoop_judge #(.NUM_CTX(NUM_CTX), .LINE_W(LINE_W), .PRIO_W(PRIO_W)) u_judge (
    .snp_valid (snoop_valid),
    .snp_line  (snoop_addr[ADDR_W-1:OFF_W]),
    .snp_prio  (snoop_prio),
    .live_i    (live_v),
    .lines_i   (lines_v),
    .prios_i   (ctx_prio),
    .kill_o    (kill_v),
    .refuse_o  (refuse)
  );

  assign live_now = live_v & ~kill_v;

  llsc_req_ctrl #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .LINE_W(LINE_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_is_sc     (req_is_sc),
    .req_ctx       (req_ctx),
    .req_line      (req_addr[ADDR_W-1:OFF_W]),
    .req_line_excl (req_line_excl),
    .fetch_valid   (fetch_valid),
    .fetch_ready   (fetch_ready),
    .fetch_line    (fetch_line),
    .fill_valid    (fill_valid),
    .live_now      (live_now),
    .lines_i       (lines_v),
    .ll_set        (ll_set_v),
    .ll_live       (ll_live),
    .fill_upd      (fill_upd_v),
    .sc_clr        (sc_clr_v),
    .done_valid    (done_valid),
    .done_ready    (done_ready),
    .done_ctx      (done_ctx),
    .done_is_sc    (done_is_sc),
    .done_sc_ok    (done_sc_ok)
  );

  assign fetch_addr = {fetch_line, OFF_W'(0)};
  assign sc_mode    = open_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snoop_rsp_valid  <= 1'b0;
      snoop_rsp_refuse <= 1'b0;
    end else begin
      snoop_rsp_valid  <= snoop_valid;
      snoop_rsp_refuse <= snoop_valid && refuse;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_is_sc,
  input logic [CTX_W-1:0]   req_ctx,
  input logic               req_line_excl,
  input logic               done_valid,
  input logic               done_ready,
  input logic [CTX_W-1:0]   done_ctx,
  input logic               done_is_sc,
  input logic               done_sc_ok,
  input logic               fetch_valid,
  input logic               fetch_ready,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic               snoop_valid,
  input logic               snoop_rsp_valid,
  input logic               snoop_rsp_refuse,
  input logic [NUM_CTX-1:0] sc_mode
);
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr)); // R1
  AST_EXCL_LL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_is_sc && req_line_excl |=> done_valid && !fetch_valid); // R2
  AST_SC_WITHOUT_MODE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_is_sc && !sc_mode[req_ctx] |=> done_valid && done_is_sc && !done_sc_ok); // R4
  AST_SNOOP_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |=> snoop_rsp_valid); // R7
  AST_REFUSE_ONLY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_rsp_valid |-> !snoop_rsp_refuse); // R7
  AST_LL_OPENS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_is_sc |=> sc_mode[$past(req_ctx)]); // R9
  AST_SC_CLOSES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_is_sc |=> !sc_mode[$past(req_ctx)]); // R9
  AST_NO_REQ_WHILE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !req_ready); // R10
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid && $stable({done_ctx, done_is_sc, done_sc_ok})); // R10
endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_is_sc        (req_is_sc),
  .req_ctx          (req_ctx),
  .req_line_excl    (req_line_excl),
  .done_valid       (done_valid),
  .done_ready       (done_ready),
  .done_ctx         (done_ctx),
  .done_is_sc       (done_is_sc),
  .done_sc_ok       (done_sc_ok),
  .fetch_valid      (fetch_valid),
  .fetch_ready      (fetch_ready),
  .fetch_addr       (fetch_addr),
  .snoop_valid      (snoop_valid),
  .snoop_rsp_valid  (snoop_rsp_valid),
  .snoop_rsp_refuse (snoop_rsp_refuse),
  .sc_mode          (sc_mode)
);

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_sc = 1'b0, req_line_excl = 1'b0;
  logic [1:0]  req_ctx = '0;
  logic [31:0] req_addr = '0;
  logic        done_ready = 1'b1, fetch_ready = 1'b0;
  logic        fill_valid = 1'b0, fill_excl = 1'b0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic [2:0]  snoop_prio = '0;
  logic [11:0] ctx_prio = '0;
  logic        req_ready, done_valid, done_is_sc, done_sc_ok, fetch_valid;
  logic        snoop_rsp_valid, snoop_rsp_refuse;
  logic [1:0]  done_ctx;
  logic [31:0] fetch_addr;
  logic [3:0]  sc_mode;

  always #10 clk = ~clk;

  llsc_monitor dut_i (.*);

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit random_phase = 0, dir_fill_excl = 1, checking = 0;
  int pend_cnt = 0;

  // reference model state
  bit         m_open[4], m_live[4];
  logic [25:0] m_line[4];
  int         m_st = 0;
  int         m_ctx = 0;
  logic [25:0] m_cur = '0;
  bit         m_dv = 0, m_dsc = 0, m_dok = 0, m_srv = 0, m_sref = 0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit refuse, hit[4], rdy;
    cycles++;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin m_open[c] = 0; m_live[c] = 0; m_line[c] = '0; end
      m_st = 0; m_ctx = 0; m_cur = '0; m_dv = 0; m_dsc = 0; m_dok = 0; m_srv = 0; m_sref = 0;
    end else begin
      refuse = 0;
      for (int c = 0; c < 4; c++) begin
        hit[c] = snoop_valid && m_live[c] && (m_line[c] == snoop_addr[31:6]);
        if (hit[c] && ctx_prio[c*3 +: 3] >= snoop_prio) refuse = 1;
      end
      m_srv = snoop_valid; m_sref = refuse;
      if (!refuse) for (int c = 0; c < 4; c++) if (hit[c]) m_live[c] = 0;
      rdy = (m_st == 0) && !m_dv;
      if (m_dv && done_ready) m_dv = 0;
      case (m_st)
        0: if (req_valid && rdy) begin
          m_ctx = req_ctx; m_cur = req_addr[31:6];
          if (req_is_sc) begin
            m_dok = m_live[req_ctx] && (m_line[req_ctx] == req_addr[31:6]);
            m_open[req_ctx] = 0; m_live[req_ctx] = 0; m_dv = 1; m_dsc = 1;
          end else begin
            m_open[req_ctx] = 1; m_line[req_ctx] = req_addr[31:6];
            m_live[req_ctx] = req_line_excl;
            if (req_line_excl) begin m_dv = 1; m_dsc = 0; m_dok = 0; end
            else m_st = 1;
          end
        end
        1: if (fetch_ready) m_st = 2;
        default: if (fill_valid) begin
          m_live[m_ctx] = fill_excl; m_dv = 1; m_dsc = 0; m_dok = 0; m_st = 0;
        end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      cmp("R10 req_ready", 32'(req_ready), 32'((m_st == 0) && !m_dv));
      cmp("R1 fetch_valid", 32'(fetch_valid), 32'(m_st == 1));
      if (m_st == 1) cmp("R1 fetch_addr", fetch_addr, {m_cur, 6'd0});
      cmp("R10 done_valid", 32'(done_valid), 32'(m_dv));
      if (m_dv) begin
        cmp("R10 done_ctx", 32'(done_ctx), 32'(m_ctx));
        cmp("R3 done_is_sc", 32'(done_is_sc), 32'(m_dsc));
        cmp("R4 done_sc_ok", 32'(done_sc_ok), 32'(m_dok));
      end
      cmp("R7 snoop_rsp_valid", 32'(snoop_rsp_valid), 32'(m_srv));
      cmp("R7 R8 snoop_rsp_refuse", 32'(snoop_rsp_refuse), 32'(m_sref));
      cmp("R9 sc_mode", 32'(sc_mode), 32'({m_open[3], m_open[2], m_open[1], m_open[0]}));
    end
  end

  // fabric responder
  always @(negedge clk) begin
    fill_valid = 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        fill_valid = 1'b1;
        fill_excl  = random_phase ? 1'($urandom % 3 != 0) : dir_fill_excl;
      end
    end
    fetch_ready = 1'($urandom % 2);
    if (fetch_valid && fetch_ready) pend_cnt = 2 + int'($urandom % 3);
    if (random_phase) done_ready = 1'($urandom % 4 != 0);
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic do_req(bit sc, int ctx, logic [31:0] addr, bit excl);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_is_sc = sc; req_ctx = 2'(ctx); req_addr = addr; req_line_excl = excl;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(string tag, bit exp_ok);
    while (!done_valid) @(negedge clk);
    cmp(tag, 32'(done_sc_ok), 32'(exp_ok));
  endtask

  task automatic snoop_at(logic [31:0] addr, logic [2:0] pr);
    snoop_valid = 1; snoop_addr = addr; snoop_prio = pr;
    @(negedge clk);
    snoop_valid = 0;
  endtask

  localparam logic [31:0] LA = 32'h0000_1000, LB = 32'h0000_2040, LC = 32'h0000_3080;

  initial begin
    ctx_prio = {3'd5, 3'd2, 3'd4, 3'd1};
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R11 reset req_ready", 32'(req_ready), 32'd1);
    cmp("R11 reset outputs", {done_valid, fetch_valid, snoop_rsp_valid, snoop_rsp_refuse, sc_mode},
        32'd0);
    rst_n = 1;
    checking = 1;

    // R2, R4, R9: exclusive-hit LL then matching SC
    do_req(0, 0, LA + 4, 1);
    cmp("R2 done after exclusive LL", 32'(done_valid), 32'd1);
    cmp("R9 mode open", 32'(sc_mode[0]), 32'd1);
    do_req(1, 0, LA + 8, 0);
    wait_done("R4 SC same line succeeds", 1);
    @(negedge clk);
    cmp("R9 mode closed", 32'(sc_mode[0]), 32'd0);
    // R5: second SC fails
    do_req(1, 0, LA, 0);
    wait_done("R5 repeated SC fails", 0);

    // R1: miss with exclusive fill
    dir_fill_excl = 1;
    do_req(0, 1, LB + 7, 0);
    cmp("R1 fetch issued", 32'(fetch_valid), 32'd1);
    cmp("R1 fetch aligned", fetch_addr, LB);
    wait_done("R1 LL completes after fill", 0);
    do_req(1, 1, LB + 60, 0);
    wait_done("R4 SC after exclusive fill", 1);
    // R3: non-exclusive fill
    dir_fill_excl = 0;
    do_req(0, 1, LB, 0);
    wait_done("R3 LL completes silently", 0);
    cmp("R3 LL reported as LL", 32'(done_is_sc), 32'd0);
    do_req(1, 1, LB, 0);
    wait_done("R3 SC after shared fill fails", 0);
    dir_fill_excl = 1;

    // R6: replacement
    do_req(0, 2, LA, 1);
    do_req(0, 2, LB, 1);
    do_req(1, 2, LB, 0);
    wait_done("R6 SC to replacing line succeeds", 1);
    do_req(0, 2, LA, 1);
    do_req(0, 2, LB, 1);
    do_req(1, 2, LA, 0);
    wait_done("R6 SC to replaced line fails", 0);
    // R4: other line
    do_req(0, 0, LA, 1);
    do_req(1, 0, LC, 0);
    wait_done("R4 SC to other line fails", 0);

    // R7: tie goes to holder (ctx3 priority 5)
    do_req(0, 3, LC, 1);
    snoop_at(LC + 1, 3'd5);
    cmp("R7 tie refused", 32'(snoop_rsp_refuse), 32'd1);
    snoop_at(LA, 3'd7);
    cmp("R7 other line not refused", 32'(snoop_rsp_refuse), 32'd0);
    do_req(1, 3, LC, 0);
    wait_done("R7 reservation kept after refusal", 1);
    // R8: higher snooper wins
    do_req(0, 3, LC, 1);
    snoop_at(LC, 3'd6);
    cmp("R8 yielded", 32'(snoop_rsp_refuse), 32'd0);
    do_req(1, 3, LC, 0);
    wait_done("R8 SC after yield fails", 0);
    // R8: snoop in the same cycle as SC
    do_req(0, 3, LC, 1);
    @(negedge clk);
    req_valid = 1; req_is_sc = 1; req_ctx = 2'd3; req_addr = LC;
    snoop_valid = 1; snoop_addr = LC; snoop_prio = 3'd7;
    @(negedge clk);
    req_valid = 0; snoop_valid = 0;
    wait_done("R8 same-cycle snoop defeats SC", 0);

    // random phase
    random_phase = 1;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      case ($urandom % 3) 0: a = LA; 1: a = LB; default: a = LC; endcase
      a[5:0] = 6'($urandom);
      if ($urandom % 3 == 0) begin
        snoop_valid = 1; snoop_addr = a; snoop_prio = 3'($urandom);
      end else snoop_valid = 0;
      if ($urandom % 50 == 0) ctx_prio = 12'($urandom);
      if (req_ready && ($urandom % 2 == 0)) begin
        req_valid = 1; req_is_sc = 1'($urandom % 2); req_ctx = 2'($urandom);
        req_addr = a; req_line_excl = 1'($urandom % 2);
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0; snoop_valid = 0; done_ready = 1;
    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule